// File: doc/BRIEF.md
# Uneven-Capacity Channel Address Mapper

This block turns a flat byte address into a target memory channel and a byte address inside that channel's device. It serves a memory system of ten 32-bit channels. Channels 0 to 5 carry 2 GB devices and channels 6 to 9 carry 1 GB devices, giving 16 GB in total. Addresses are cut into 256-byte granules, and consecutive granules go to consecutive channels in ascending order.

Below 10 GB every granule rotates over all ten channels. These accesses fill the small devices and the bottom half of each large one. From 10 GB up to 16 GB only the six large devices have room, so granules rotate over channels 0 to 5 only and land in the top half of each large device. That upper window therefore offers six tenths of the full bus width. Each result is tagged with the window it came from. An address outside the 16 GB space is tagged as an error and selects no channel.

The mapper is a two-stage pipeline with valid/ready handshakes on both sides. It accepts one address per cycle. The division and remainder by ten and by six are done with a constant-reciprocal multiply in the first stage and a single correction step in the second stage.

Top module: `mapperTop`

## Requirements
- R1: After reset `outValid` is low and `inReady` is high.
- R2: For an address A below 10 GB with granule G = A div 256, `outRegion` is 0, `outChannel` is G mod 10 and `outOffset` is (G div 10)·256 + (A mod 256).
- R3: The address exactly at 10 GB maps to region 1, channel 0, offset 1 GB.
- R4: For A from 10 GB up to but not including 16 GB, with H = (A − 10 GB) div 256, `outRegion` is 1, `outChannel` is H mod 6 and `outOffset` is 2^30 + (H div 6)·256 + (A mod 256).
- R5: Every region-1 result names a channel below 6 and has offset bit 30 set. Every region-0 result has offset bit 30 clear.
- R6: Any address at or above 16 GB gives `outRegion` 2 with `outChSel`, `outChannel` and `outOffset` all zero. Region code 3 never appears.
- R7: For regions 0 and 1, `outChSel` is one-hot with bit `outChannel` set.
- R8: With `outReady` held high, a result is offered two clock edges after its address is accepted, and back-to-back addresses are accepted one per cycle. Whenever the output stage is empty, `inReady` is high.
- R9: While `outValid` is high and `outReady` is low, every output holds steady. Results leave in acceptance order and none are lost or duplicated.
- R10: The last byte of each window maps to the last device byte: 10 GB − 1 gives channel 9, offset 2^30 − 1; 16 GB − 1 gives channel 5, offset 2^31 − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Address offered |
| inReady | output | 1 | Address accepted on this edge if valid |
| inAddr | input | 36 | Flat byte address |
| outValid | output | 1 | Mapping result offered |
| outReady | input | 1 | Consumer takes the result |
| outRegion | output | 2 | 0 full-width window, 1 wide-only window, 2 out of range |
| outChannel | output | 4 | Channel index |
| outChSel | output | 10 | One-hot channel select |
| outOffset | output | 31 | Byte address within the device |

## Verification
The bench builds the mapper with its default parameters. These are ten channels, six of them large, a 256-byte granule, a 1 GB unit of device capacity and a 36-bit address. This exact geometry is what the bench's independent model uses. The 36-bit address reaches well past 16 GB, so the error window is exercised along with both interleave windows and the edges between them. The 28-bit granule index sets the reciprocal precision. Random addresses across the whole space therefore test the one-step correction of the quotient at the size where an error in the reciprocal would first show.

// File: rtl/mapPkg.sv
package mapPkg;

  // Window that an address falls into; the code values are visible at the ports.
  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_HIGH = 2'd1,
    REG_NONE = 2'd2
  } regionE;

  // Strobes from the pipeline control to the datapath registers.
  typedef struct packed {
    logic loadFront;
    logic loadBack;
  } stepCtrlS;

endpackage

// File: rtl/mapDivEst.sv
// Quotient estimate by a constant divisor: multiply by floor(2^SHIFT/DIVISOR).
// The result is the true quotient or one less; the caller corrects it.
module mapDivEst #(
  parameter int NUM_W   = 28,
  parameter int QUOT_W  = 22,
  parameter int DIVISOR = 10
) (
  input  logic [NUM_W-1:0]  numer,
  output logic [QUOT_W-1:0] quot
);
  localparam int SHIFT  = NUM_W + 4;
  localparam int PROD_W = NUM_W + SHIFT;
  localparam longint unsigned RECIP_L = (64'd1 << SHIFT) / DIVISOR;
  localparam logic [SHIFT-1:0] RECIP = SHIFT'(RECIP_L);

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = {{SHIFT{1'b0}}, numer} * {{NUM_W{1'b0}}, RECIP};
  end

  assign quot = QUOT_W'(prod >> SHIFT);
endmodule

// File: rtl/mapCtrl.sv
module mapCtrl
  import mapPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output stepCtrlS strobes
);
  logic frontV;
  logic backV;
  logic advBack;
  logic advFront;

  always_comb begin
    advBack           = !backV || outReady;
    advFront          = !frontV || advBack;
    strobes.loadFront = advFront && inValid;
    strobes.loadBack  = advBack && frontV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontV <= 1'b0;
      backV  <= 1'b0;
    end else begin
      if (advFront) frontV <= inValid;
      if (advBack)  backV  <= frontV;
    end
  end

  assign inReady  = advFront;
  assign outValid = backV;
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import mapPkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int GRAN_BITS = 8,
  parameter int DEV_LOG2  = 30,
  parameter int NUM_CH    = 10,
  parameter int NUM_WIDE  = 6,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int OFF_W    = DEV_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtrlS          strobes,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [1:0]        outRegion,
  output logic [CH_W-1:0]   outChannel,
  output logic [NUM_CH-1:0] outChSel,
  output logic [OFF_W-1:0]  outOffset
);
  localparam int GW = ADDR_W - GRAN_BITS;
  localparam int QW = DEV_LOG2 - GRAN_BITS;
  localparam longint unsigned LOW_BYTES = longint'(NUM_CH) << DEV_LOG2;
  localparam longint unsigned TOP_BYTES = LOW_BYTES + (longint'(NUM_WIDE) << DEV_LOG2);
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(LOW_BYTES);
  localparam logic [ADDR_W-1:0] TOP_LIMIT = ADDR_W'(TOP_BYTES);
  localparam logic [GW-1:0] HIGH_BASE_G = GW'(LOW_BYTES >> GRAN_BITS);

  // ---------------- stage 1: window decode and quotient estimate
  logic [GW-1:0]        gran;
  logic [GW-1:0]        granHigh;
  logic [GRAN_BITS-1:0] byteIn;
  logic [QW-1:0]        qLow;
  logic [QW-1:0]        qHigh;
  regionE               regionIn;

  always_comb begin
    gran     = inAddr[ADDR_W-1:GRAN_BITS];
    byteIn   = inAddr[GRAN_BITS-1:0];
    granHigh = gran - HIGH_BASE_G;
    if (inAddr < LOW_LIMIT)      regionIn = REG_LOW;
    else if (inAddr < TOP_LIMIT) regionIn = REG_HIGH;
    else                         regionIn = REG_NONE;
  end

  mapDivEst #(.NUM_W(GW), .QUOT_W(QW), .DIVISOR(NUM_CH)) uDivLow (
    .numer(gran),
    .quot (qLow)
  );

  mapDivEst #(.NUM_W(GW), .QUOT_W(QW), .DIVISOR(NUM_WIDE)) uDivHigh (
    .numer(granHigh),
    .quot (qHigh)
  );

  regionE               fRegion;
  logic [GW-1:0]        fNumer;
  logic [QW-1:0]        fQ;
  logic [GRAN_BITS-1:0] fByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fRegion <= REG_NONE;
      fNumer  <= '0;
      fQ      <= '0;
      fByte   <= '0;
    end else if (strobes.loadFront) begin
      fRegion <= regionIn;
      fByte   <= byteIn;
      if (regionIn == REG_HIGH) begin
        fNumer <= granHigh;
        fQ     <= qHigh;
      end else begin
        fNumer <= gran;
        fQ     <= qLow;
      end
    end
  end

  // ---------------- stage 2: correction and offset assembly
  logic [GW-1:0] divW;
  logic [GW-1:0] rem;
  logic [GW-1:0] remFix;
  logic          fix;
  logic [QW-1:0] qFix;

  always_comb begin
    divW   = (fRegion == REG_HIGH) ? GW'(NUM_WIDE) : GW'(NUM_CH);
    rem    = fNumer - ({{(GW-QW){1'b0}}, fQ} * divW);
    fix    = (rem >= divW);
    qFix   = fQ + QW'(fix);
    remFix = fix ? (rem - divW) : rem;
  end

  regionE           bRegion;
  logic [CH_W-1:0]  bChan;
  logic [OFF_W-1:0] bOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bRegion <= REG_NONE;
      bChan   <= '0;
      bOff    <= '0;
    end else if (strobes.loadBack) begin
      bRegion <= fRegion;
      if (fRegion == REG_NONE) begin
        bChan <= '0;
        bOff  <= '0;
      end else begin
        bChan <= CH_W'(remFix);
        bOff  <= {fRegion == REG_HIGH, qFix, fByte};
      end
    end
  end

  // one-hot select, one decoder bit per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : gSel
    assign outChSel[c] = (bRegion != REG_NONE) && (bChan == CH_W'(c));
  end

  assign outRegion  = bRegion;
  assign outChannel = bChan;
  assign outOffset  = bOff;
endmodule

// File: rtl/mapperTop.sv
module mapperTop
  import mapPkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int GRAN_BITS = 8,
  parameter int DEV_LOG2  = 30,
  parameter int NUM_CH    = 10,
  parameter int NUM_WIDE  = 6,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int OFF_W    = DEV_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outRegion,
  output logic [CH_W-1:0]   outChannel,
  output logic [NUM_CH-1:0] outChSel,
  output logic [OFF_W-1:0]  outOffset
);
  stepCtrlS strobes;

  mapCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  mapDatapath #(
    .ADDR_W   (ADDR_W),
    .GRAN_BITS(GRAN_BITS),
    .DEV_LOG2 (DEV_LOG2),
    .NUM_CH   (NUM_CH),
    .NUM_WIDE (NUM_WIDE)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inAddr    (inAddr),
    .outRegion (outRegion),
    .outChannel(outChannel),
    .outChSel  (outChSel),
    .outOffset (outOffset)
  );
endmodule

// File: rtl/mapperChecker.sv
module mapperChecker #(
  parameter int NUM_CH   = 10,
  parameter int NUM_WIDE = 6,
  parameter int CH_W     = 4,
  parameter int OFF_W    = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outRegion,
  input logic [CH_W-1:0]   outChannel,
  input logic [NUM_CH-1:0] outChSel,
  input logic [OFF_W-1:0]  outOffset
);
  // R6: out-of-range results select nothing
  a_r6_none_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion == 2'd2) |-> (outChSel == '0 && outChannel == '0 && outOffset == '0));

  // R6: region code 3 is never produced
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outRegion != 2'd3));

  // R7: in-range results drive exactly one select line
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion != 2'd2) |-> ($countones(outChSel) == 1));

  // R5: upper window stays on the large devices, top half
  a_r5_high_wide: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion == 2'd1) |-> (outChannel < CH_W'(NUM_WIDE) && outOffset[OFF_W-1]));

  // R5: lower window stays in the bottom half
  a_r5_low_half: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRegion == 2'd0) |-> (!outOffset[OFF_W-1] && outChannel < CH_W'(NUM_CH)));

  // R9: a stalled result holds steady
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outChannel) && $stable(outOffset)
                                 && $stable(outRegion) && $stable(outChSel)));

  // R8: an empty output stage never blocks the input
  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

bind mapperTop mapperChecker #(
  .NUM_CH  (NUM_CH),
  .NUM_WIDE(NUM_WIDE),
  .CH_W    (CH_W),
  .OFF_W   (OFF_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outRegion (outRegion),
  .outChannel(outChannel),
  .outChSel  (outChSel),
  .outOffset (outOffset)
);

// File: tb/mapperTop_bench.sv
`timescale 1ns/1ps
module mapperTop_bench;
  localparam int ADDR_W = 36;
  localparam int NUM_CH = 10;
  localparam int CH_W   = 4;
  localparam int OFF_W  = 31;
  localparam longint unsigned GB   = 64'd1 << 30;
  localparam longint unsigned LOWB = 10 * GB;
  localparam longint unsigned TOPB = 16 * GB;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [ADDR_W-1:0] inAddr = '0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [1:0]        outRegion;
  logic [CH_W-1:0]   outChannel;
  logic [NUM_CH-1:0] outChSel;
  logic [OFF_W-1:0]  outOffset;

  mapperTop u_mapperTop (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .outValid(outValid), .outReady(outReady), .outRegion(outRegion),
    .outChannel(outChannel), .outChSel(outChSel), .outOffset(outOffset)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    longint unsigned addr;
    int              region;
    int              chan;
    longint unsigned off;
    longint          acceptCyc;
    bit              latChk;
    string           tag;
  } itemT;

  itemT   expQ[$];
  int     nChecks = 0;
  int     nFails  = 0;
  longint cyc = 0;
  bit     stallMode = 1'b0;
  longint unsigned rng = 64'h9E3779B97F4A7C15;
  longint firstAcc;
  longint lastAcc;
  bit     done = 1'b0;

  always @(posedge clk) cyc++;

  function automatic longint unsigned nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic check(string req, bit ok, string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic itemT model(longint unsigned a, string tag);
    itemT it;
    longint unsigned g;
    it.addr = a;
    it.tag  = tag;
    if (a < LOWB) begin
      g = a >> 8;
      it.region = 0;
      it.chan   = int'(g % 10);
      it.off    = (g / 10) * 256 + (a % 256);
      if (tag == "") it.tag = "R2";
    end else if (a < TOPB) begin
      g = (a - LOWB) >> 8;
      it.region = 1;
      it.chan   = int'(g % 6);
      it.off    = GB + (g / 6) * 256 + (a % 256);
      if (tag == "") it.tag = "R4";
    end else begin
      it.region = 2;
      it.chan   = 0;
      it.off    = 0;
      if (tag == "") it.tag = "R6";
    end
    return it;
  endfunction

  // driver: offer one address, push the expected result when it is accepted
  task automatic send(longint unsigned a, bit latChk, string tag);
    itemT it;
    @(negedge clk);
    inValid = 1'b1;
    inAddr  = ADDR_W'(a);
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    it = model(a, tag);
    it.acceptCyc = cyc;
    it.latChk = latChk;
    expQ.push_back(it);
    if (firstAcc < 0) firstAcc = cyc;
    lastAcc = cyc;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // consumer readiness
  always @(negedge clk) begin
    if (stallMode) outReady <= (nextRand() % 3) != 0;
    else           outReady <= 1'b1;
  end

  // monitor: compare results against the scoreboard
  logic [1:0]       hRegion;
  logic [CH_W-1:0]  hChan;
  logic [OFF_W-1:0] hOff;
  bit               holdPending = 1'b0;

  always @(negedge clk) begin
    itemT e;
    logic [NUM_CH-1:0] expSel;
    #2;
    if (rstN && outValid) begin
      if (holdPending) begin
        check("R9", outRegion == hRegion && outChannel == hChan && outOffset == hOff,
              $sformatf("held result moved: got r%0d ch%0d off%0h exp r%0d ch%0d off%0h",
                        outRegion, outChannel, outOffset, hRegion, hChan, hOff));
      end
      holdPending = 1'b0;
      if (outReady) begin
        if (expQ.size() == 0) begin
          check("R9", 1'b0, "result with no pending request: got one, expected none");
        end else begin
          e = expQ.pop_front();
          check(e.tag, outRegion == 2'(e.region) && outChannel == CH_W'(e.chan)
                       && outOffset == OFF_W'(e.off),
                $sformatf("addr %0h: got r%0d ch%0d off%0h exp r%0d ch%0d off%0h", e.addr,
                          outRegion, outChannel, outOffset, e.region, e.chan, e.off));
          expSel = (e.region == 2) ? '0 : NUM_CH'(1) << e.chan;
          check(e.region == 2 ? "R6" : "R7", outChSel == expSel,
                $sformatf("addr %0h sel: got %b exp %b", e.addr, outChSel, expSel));
          if (e.region == 1)
            check("R5", outChannel < 6 && outOffset[OFF_W-1],
                  $sformatf("addr %0h: got ch%0d bit30=%0d exp ch<6 bit30=1",
                            e.addr, outChannel, outOffset[OFF_W-1]));
          if (e.latChk)
            check("R8", cyc == e.acceptCyc + 2,
                  $sformatf("latency: got %0d exp %0d", cyc - e.acceptCyc, 2));
        end
      end else begin
        holdPending = 1'b1;
        hRegion = outRegion;
        hChan   = outChannel;
        hOff    = outOffset;
      end
    end else begin
      holdPending = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got run still busy, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    firstAcc = -1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", outValid == 1'b0 && inReady == 1'b1,
          $sformatf("after reset: got valid%0d ready%0d exp valid0 ready1", outValid, inReady));

    // directed corners, consumer always ready
    send(64'd0, 1'b1, "R2");
    send(64'd255, 1'b1, "R2");
    send(64'd256, 1'b1, "R2");
    send(64'd9 * 256 + 7, 1'b1, "R2");
    send(64'd10 * 256 + 1, 1'b1, "R2");
    send(LOWB - 1, 1'b1, "R10");
    send(LOWB, 1'b1, "R3");
    send(LOWB + 5 * 256 + 3, 1'b1, "R4");
    send(LOWB + 6 * 256 + 9, 1'b1, "R4");
    send(12 * GB + 12345, 1'b1, "R4");
    send(TOPB - 1, 1'b1, "R10");
    send(TOPB, 1'b1, "R6");
    send((64'd1 << ADDR_W) - 1, 1'b1, "R6");
    idle();
    repeat (4) @(negedge clk);

    // throughput: twenty back-to-back accepts
    firstAcc = -1;
    for (int i = 0; i < 20; i++) send(nextRand() % TOPB, 1'b1, "");
    idle();
    check("R8", lastAcc - firstAcc == 19,
          $sformatf("20 accepts span: got %0d exp 19 cycles", lastAcc - firstAcc));
    repeat (4) @(negedge clk);

    // random addresses with a hesitant consumer
    stallMode = 1'b1;
    for (int i = 0; i < 400; i++) send(nextRand() % (17 * GB), 1'b0, "");
    idle();
    stallMode = 1'b0;
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9", expQ.size() == 0,
          $sformatf("results outstanding: got %0d exp 0", expQ.size()));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule